// File: doc/BRIEF.md
# Receive Line Break Detector

This block sits beside an asynchronous serial receiver and watches the already synchronized receive line for break conditions. It measures how long the line stays low, counted in bit times, and compares that duration against two thresholds taken from the current character format. The format length M is the total bit count of one character: one start bit, seven to nine data bits, an optional parity bit and one stop bit, so M is 9 to 12. A low level longer than M bit times is a short break. A low level longer than 2M+3 bit times is a long break.

Counting moves only on a bit-time tick supplied by the baud generator. If the line falls while the receiver is in the middle of a character, that character runs to completion and the block reports a framing-error pulse when the frame ends with the line still low. Break timing begins only after that point. Both break flags stay set until software clears them through a masked write strobe.

Top module: `uart_brk_detect`

## Requirements
- R1: The character length M is 1 + D + P + 1, where D is 7 for `data_sel`=2'b00, 8 for 2'b01 and 9 for 2'b10 or 2'b11, and P is 1 when `parity_en` is high, else 0.
- R2: `short_brk` becomes 1 on the clock edge that samples the (M+1)-th consecutive low bit tick counted outside a frame.
- R3: `long_brk` becomes 1 on the clock edge that samples the (2M+4)-th consecutive low bit tick counted outside a frame.
- R4: While `frame_active` is high, no low ticks are counted and neither flag sets; break timing starts from zero at the first tick after `frame_active` falls.
- R5: When `frame_active` falls while `rxd` is low, `frame_err` is high for exactly one cycle, in the cycle after that edge.
- R6: Both flags are sticky: a high line or further ticks never clear them.
- R7: A clear strobe `clr_stb` with `clr_mask` bit 0 clears `short_brk` and bit 1 clears `long_brk`; a flag whose mask bit is 0 is kept.
- R8: If a flag's set condition and its clear occur in the same cycle, the flag ends up set.
- R9: One unbroken low period sets each flag at most once; after a clear, further low ticks do not set it again until the line has been seen high on a tick.
- R10: The low count saturates instead of wrapping, so a very long low period never sets a cleared flag again.
- R11: Without a bit tick, changes on `rxd` have no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle pulse once per bit time |
| rxd | input | 1 | Synchronized receive line level |
| frame_active | input | 1 | High while the receiver is inside a character |
| data_sel | input | 2 | Data bit count select (00=7, 01=8, 1x=9) |
| parity_en | input | 1 | Parity bit present in the character |
| clr_stb | input | 1 | One-cycle clear strobe from software |
| clr_mask | input | 2 | Bit 0 clears short break, bit 1 clears long break |
| short_brk | output | 1 | Sticky short-break flag |
| long_brk | output | 1 | Sticky long-break flag |
| frame_err | output | 1 | One-cycle pulse: frame ended with the line low |

## Verification
The assertions check every cycle that flags stay set unless a masked clear arrives, that flags change only on a tick or a clear, that no flag rises while a frame is active or without a tick in the previous cycle, and that the framing pulse lasts one cycle. The exact tick on which each threshold is crossed for several formats, the deferral of timing to the end of a frame, the single firing per low period and the saturation over a very long low level can only be shown by the bench's directed scenarios.

// File: rtl/brk_pkg.sv
package brk_pkg;

    // Width of the low-duration counter; must hold 2*12+4 = 28.
    localparam int BRK_CNT_W = 5;
    localparam int BRK_FLAG_N = 2;

    typedef enum logic [1:0] {
        DSEL_7 = 2'b00,
        DSEL_8 = 2'b01,
        DSEL_9 = 2'b10
    } dsel_e;

    typedef struct packed {
        logic [BRK_CNT_W-1:0] cnt;
        logic                 armed;
        logic                 fa;
        logic                 fe;
    } low_cnt_t;

    typedef struct packed {
        logic [BRK_FLAG_N-1:0] flag;
    } flag_st_t;

endpackage

// File: rtl/brk_frame_len.sv
module brk_frame_len #(
    parameter int CNT_W = brk_pkg::BRK_CNT_W
) (
    input  logic [1:0]       data_sel,
    input  logic             parity_en,
    output logic [CNT_W-1:0] thr_short,
    output logic [CNT_W-1:0] thr_long
);
    import brk_pkg::*;

    logic [CNT_W-1:0] data_n;
    logic [CNT_W-1:0] m_len;

    // R1: character length from the configured format
    always_comb begin
        case (data_sel)
            DSEL_7:  data_n = CNT_W'(7);
            DSEL_8:  data_n = CNT_W'(8);
            default: data_n = CNT_W'(9);
        endcase
        m_len     = data_n + CNT_W'(2) + (parity_en ? CNT_W'(1) : CNT_W'(0));
        thr_short = m_len;
        thr_long  = (m_len << 1) + CNT_W'(3);
    end

endmodule

// File: rtl/brk_low_counter.sv
module brk_low_counter #(
    parameter int CNT_W = brk_pkg::BRK_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             rxd,
    input  logic             frame_active,
    input  logic [CNT_W-1:0] thr_short,
    input  logic [CNT_W-1:0] thr_long,
    output logic             short_hit,
    output logic             long_hit,
    output logic             frame_err
);
    import brk_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    low_cnt_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        short_hit = 1'b0;
        long_hit  = 1'b0;
        st_d.fa   = frame_active;
        // R5: frame closed while the line is still low
        st_d.fe   = st_q.fa & ~frame_active & ~rxd;
        if (bit_tick) begin
            if (frame_active) begin
                // R4: timing deferred until the frame ends
                st_d.cnt   = '0;
                st_d.armed = 1'b1;
            end else if (rxd) begin
                st_d.cnt   = '0;
                st_d.armed = 1'b1;
            end else if (st_q.armed) begin
                // R10: hold once past the long threshold
                if (st_q.cnt <= thr_long) begin
                    st_d.cnt  = st_q.cnt + ONE;
                    short_hit = (st_d.cnt == thr_short + ONE);
                    long_hit  = (st_d.cnt == thr_long + ONE);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_err = st_q.fe;

endmodule

// File: rtl/brk_flags.sv
module brk_flags #(
    parameter int FLAG_N = brk_pkg::BRK_FLAG_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_N-1:0] set_vec,
    input  logic              clr_stb,
    input  logic [FLAG_N-1:0] clr_mask,
    output logic [FLAG_N-1:0] flags
);
    import brk_pkg::*;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < FLAG_N; i++) begin
            // R7 masked clear, R8 set has priority
            if (clr_stb && clr_mask[i]) st_d.flag[i] = 1'b0;
            if (set_vec[i])             st_d.flag[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flag;

endmodule

// File: rtl/uart_brk_detect.sv
module uart_brk_detect (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic       rxd,
    input  logic       frame_active,
    input  logic [1:0] data_sel,
    input  logic       parity_en,
    input  logic       clr_stb,
    input  logic [1:0] clr_mask,
    output logic       short_brk,
    output logic       long_brk,
    output logic       frame_err
);
    import brk_pkg::*;

    localparam int CW = BRK_CNT_W;

    logic [CW-1:0] thr_short;
    logic [CW-1:0] thr_long;
    logic          short_hit;
    logic          long_hit;
    logic [1:0]    flags;

    brk_frame_len #(.CNT_W(CW)) u_len (
        .data_sel  (data_sel),
        .parity_en (parity_en),
        .thr_short (thr_short),
        .thr_long  (thr_long)
    );

    brk_low_counter #(.CNT_W(CW)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_tick     (bit_tick),
        .rxd          (rxd),
        .frame_active (frame_active),
        .thr_short    (thr_short),
        .thr_long     (thr_long),
        .short_hit    (short_hit),
        .long_hit     (long_hit),
        .frame_err    (frame_err)
    );

    brk_flags #(.FLAG_N(2)) u_flg (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  ({long_hit, short_hit}),
        .clr_stb  (clr_stb),
        .clr_mask (clr_mask),
        .flags    (flags)
    );

    assign short_brk = flags[0];
    assign long_brk  = flags[1];

endmodule

// File: rtl/brk_checker.sv
module brk_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_tick,
    input logic       frame_active,
    input logic       clr_stb,
    input logic [1:0] clr_mask,
    input logic       short_brk,
    input logic       long_brk,
    input logic       frame_err
);

    a_r6_short_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        short_brk && !(clr_stb && clr_mask[0]) |=> short_brk);

    a_r6_long_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        long_brk && !(clr_stb && clr_mask[1]) |=> long_brk);

    a_r11_no_tick_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick && !clr_stb |=> $stable(short_brk) && $stable(long_brk));

    a_r4_no_set_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        frame_active |=> !$rose(short_brk) && !$rose(long_brk));

    a_r2_short_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> !$rose(short_brk));

    a_r3_long_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> !$rose(long_brk));

    a_r5_fe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

endmodule

bind uart_brk_detect brk_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_tick     (bit_tick),
    .frame_active (frame_active),
    .clr_stb      (clr_stb),
    .clr_mask     (clr_mask),
    .short_brk    (short_brk),
    .long_brk     (long_brk),
    .frame_err    (frame_err)
);

// File: tb/uart_brk_detect_tb.sv
module uart_brk_detect_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       frame_active = 1'b0;
    logic [1:0] data_sel = 2'b01;
    logic       parity_en = 1'b0;
    logic       clr_stb = 1'b0;
    logic [1:0] clr_mask = 2'b00;
    logic       short_brk;
    logic       long_brk;
    logic       frame_err;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_brk_detect u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_tick     (bit_tick),
        .rxd          (rxd),
        .frame_active (frame_active),
        .data_sel     (data_sel),
        .parity_en    (parity_en),
        .clr_stb      (clr_stb),
        .clr_mask     (clr_mask),
        .short_brk    (short_brk),
        .long_brk     (long_brk),
        .frame_err    (frame_err)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // one bit tick with the given line level; outputs sampled at the next negedge
    task automatic tick(input logic lvl);
        @(negedge clk);
        rxd = lvl;
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
    endtask

    task automatic clear(input logic [1:0] m);
        @(negedge clk);
        clr_stb = 1'b1;
        clr_mask = m;
        @(negedge clk);
        clr_stb = 1'b0;
        clr_mask = 2'b00;
    endtask

    function automatic int m_of(input logic [1:0] ds, input logic p);
        int d;
        d = (ds == 2'b00) ? 7 : (ds == 2'b01) ? 8 : 9;
        return 2 + d + (p ? 1 : 0);
    endfunction

    // R1 R2 R3: thresholds for a given format
    task automatic t_thresholds(input logic [1:0] ds, input logic p);
        int m;
        data_sel = ds;
        parity_en = p;
        m = m_of(ds, p);
        clear(2'b11);
        tick(1'b1);
        for (int i = 1; i <= 2 * m + 4; i++) begin
            tick(1'b0);
            if (i == m)         chk("R2 short before threshold", short_brk, 1'b0);
            if (i == m + 1)     chk("R2 R1 short at M+1", short_brk, 1'b1);
            if (i == 2 * m + 3) chk("R3 long before threshold", long_brk, 1'b0);
            if (i == 2 * m + 4) chk("R3 R1 long at 2M+4", long_brk, 1'b1);
        end
        tick(1'b1);
    endtask

    task automatic t_sticky_clear;
        tick(1'b1);
        tick(1'b1);
        chk("R6 short sticky", short_brk, 1'b1);
        chk("R6 long sticky", long_brk, 1'b1);
        clear(2'b01);
        chk("R7 short cleared", short_brk, 1'b0);
        chk("R7 long kept", long_brk, 1'b1);
        clear(2'b10);
        chk("R7 long cleared", long_brk, 1'b0);
    endtask

    // R9 R10: clear mid-break, then stay low a long time
    task automatic t_once_saturate;
        int m;
        data_sel = 2'b01;
        parity_en = 1'b0;
        m = m_of(2'b01, 1'b0);
        tick(1'b1);
        for (int i = 0; i < m + 1; i++) tick(1'b0);
        chk("R2 short set", short_brk, 1'b1);
        clear(2'b11);
        for (int i = 0; i < m + 2; i++) tick(1'b0);
        chk("R9 short not set twice", short_brk, 1'b0);
        for (int i = 0; i < 3 * m; i++) tick(1'b0);
        clear(2'b11);
        for (int i = 0; i < 40; i++) tick(1'b0);
        chk("R10 short stays clear", short_brk, 1'b0);
        chk("R10 long stays clear", long_brk, 1'b0);
        tick(1'b1);
        for (int i = 0; i < m + 1; i++) tick(1'b0);
        chk("R9 rearmed after high", short_brk, 1'b1);
        tick(1'b1);
        clear(2'b11);
    endtask

    // R4 R5: low begins inside a frame
    task automatic t_defer;
        int m;
        m = m_of(data_sel, parity_en);
        tick(1'b1);
        @(negedge clk);
        frame_active = 1'b1;
        for (int i = 0; i < 2 * m + 6; i++) tick(1'b0);
        chk("R4 no short in frame", short_brk, 1'b0);
        chk("R4 no long in frame", long_brk, 1'b0);
        frame_active = 1'b0;
        @(negedge clk);
        chk("R5 frame_err pulse", frame_err, 1'b1);
        @(negedge clk);
        chk("R5 frame_err one cycle", frame_err, 1'b0);
        for (int i = 1; i <= m + 1; i++) begin
            tick(1'b0);
            if (i == m)     chk("R4 short not early", short_brk, 1'b0);
            if (i == m + 1) chk("R4 short after frame", short_brk, 1'b1);
        end
        tick(1'b1);
        clear(2'b11);
        // frame ends with the line high: no pulse
        @(negedge clk);
        frame_active = 1'b1;
        @(negedge clk);
        frame_active = 1'b0;
        @(negedge clk);
        chk("R5 no pulse when high", frame_err, 1'b0);
    endtask

    // R8: set and clear in the same cycle
    task automatic t_set_wins;
        int m;
        m = m_of(data_sel, parity_en);
        tick(1'b1);
        for (int i = 0; i < m; i++) tick(1'b0);
        @(negedge clk);
        rxd = 1'b0;
        bit_tick = 1'b1;
        clr_stb = 1'b1;
        clr_mask = 2'b11;
        @(negedge clk);
        bit_tick = 1'b0;
        clr_stb = 1'b0;
        clr_mask = 2'b00;
        chk("R8 set wins over clear", short_brk, 1'b1);
        tick(1'b1);
        clear(2'b11);
    endtask

    // R11: no ticks, line toggled low for long
    task automatic t_no_tick;
        tick(1'b1);
        @(negedge clk);
        rxd = 1'b0;
        repeat (100) @(negedge clk);
        chk("R11 short without tick", short_brk, 1'b0);
        chk("R11 long without tick", long_brk, 1'b0);
        rxd = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("reset short", short_brk, 1'b0);
        chk("reset long", long_brk, 1'b0);
        chk("reset frame_err", frame_err, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_thresholds(2'b01, 1'b0);
        t_sticky_clear();
        t_thresholds(2'b00, 1'b0);
        t_thresholds(2'b10, 1'b1);
        t_thresholds(2'b11, 1'b0);
        t_once_saturate();
        t_defer();
        t_set_wins();
        t_no_tick();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule